// File: doc/BRIEF.md
# Master-ID Address Permission Filter

This block sits on a shared AHB-Lite slave path that two kinds of bus master use: one trusted master and any number of untrusted masters, told apart by the master ID that comes with each transfer. In the address phase it decides whether the transfer may go on to the slave. A transfer that is allowed reaches the slave port unchanged, and the slave's response comes back unchanged. A transfer that is denied never raises the slave select. The block answers it with the two-cycle AHB ERROR response.

The trusted master may reach every address. An untrusted master may reach an address only if one of a small set of programmable regions covers it and permits the transfer direction. A fixed secure window, which holds the secure peripheral group and the crypto engine, stays closed to untrusted masters whatever the regions say. The region registers sit in a small configuration window inside the filter. Only the trusted master may access that window. The trusted master can also set a lock bit, which freezes the rule set until the next reset. The usual sequence is to program the regions during boot and then lock them.

Top module: `master_perm_filter`

## Requirements
- R1: A transfer whose master ID equals TRUSTED_ID (default 0) and whose address is outside the configuration window is forwarded. This holds for any address, the secure window included: sSel follows hSel in the address phase.
- R2: A transfer from any other master ID is forwarded only if some region satisfies base <= address <= limit (both inclusive) and has the permission bit for the transfer direction set. The read bit is bit 0 of the region's permission register and the write bit is bit 1. Any other transfer from that master is denied.
- R3: An untrusted transfer whose address lies in the secure window [SEC_BASE, SEC_LIMIT] is denied even when a region covers it with both permissions.
- R4: A denied transfer keeps sSel low and sTrans IDLE (2'b00). Its data phase lasts exactly two cycles: first hReadyOut=0 with hResp=1, then hReadyOut=1 with hResp=1.
- R5: During the data phase of a forwarded transfer, hReadyOut, hResp and hRdata follow sReadyOut, sResp and sRdata, wait states included.
- R6: The configuration window is the 256-byte block at CFG_BASE (default 0x4000_0000). Region i uses offset 16*i for its base, 16*i+4 for its limit and 16*i+8 for its permissions. The lock bit is bit 0 at offset 0x80. The trusted master writes these registers and reads them back with a zero-wait OKAY response, and such an access never reaches the slave.
- R7: An untrusted read or write to the configuration window gets the R4 error response and leaves every register unchanged.
- R8: Once the trusted master writes 1 to the lock bit, later writes to the region registers or to the lock bit have no effect until reset. Those writes still get OKAY.
- R9: After reset every region register and the lock bit read 0, and every untrusted transfer is denied.
- R10: The decision uses the master ID presented with the address phase. Every nonzero ID counts as untrusted, so the same address can be forwarded for ID 0 and denied for another ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hSel | input | 1 | Upstream slave select |
| hAddr | input | AW | Upstream address |
| hTrans | input | 2 | Upstream transfer type |
| hWrite | input | 1 | Upstream direction, 1 = write |
| hWdata | input | DW | Upstream write data (data phase) |
| hMaster | input | MIDW | ID of the master that drives the address phase |
| hReady | input | 1 | Bus-wide ready |
| hReadyOut | output | 1 | Ready returned upstream |
| hResp | output | 1 | Response upstream, 1 = ERROR |
| hRdata | output | DW | Read data upstream |
| sSel | output | 1 | Slave select, raised only for forwarded transfers |
| sAddr | output | AW | Address to the slave |
| sTrans | output | 2 | Transfer type to the slave, IDLE unless forwarded |
| sWrite | output | 1 | Direction to the slave |
| sWdata | output | DW | Write data to the slave |
| sRdata | input | DW | Read data from the slave |
| sReadyOut | input | 1 | Ready from the slave |
| sResp | input | 1 | Response from the slave |

## Verification
The hardest case to reach from the ports is an untrusted transfer that lands exactly on a region boundary, or inside the secure window while a region also covers it. To set that up, the regions must first be programmed over the bus by the trusted master. Directed transfers then probe base, limit, limit+4 and base-4 for each direction, and one region is deliberately stretched across the secure window. After that, random regions and random transfers from several master IDs, with random slave wait states, are checked against a bench model of the region table. The lock is tried last by writing over the locked registers and reading them back.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

  // Data phase the filter is currently answering
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FWD  = 3'd1,
    PH_CFG  = 3'd2,
    PH_ERR1 = 3'd3,
    PH_ERR2 = 3'd4
  } phase_e;

  // Strobes from control to the rule datapath
  typedef struct packed {
    logic capture;   // latch the configuration offset
    logic cfgWrite;  // commit hWdata into the addressed register
  } strobe_t;

  localparam int CFG_OFF_W = 6;  // word offset bits of the 256-byte window

endpackage

// File: rtl/mpf_rules.sv
module mpf_rules
  import mpf_pkg::*;
#(
  parameter int              AW        = 32,
  parameter int              DW        = 32,
  parameter int              NREG      = 4,
  parameter logic [AW-1:0]   CFG_BASE  = 32'h4000_0000,
  parameter logic [AW-1:0]   SEC_BASE  = 32'h5000_0000,
  parameter logic [AW-1:0]   SEC_LIMIT = 32'h5000_FFFF
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [AW-1:0] hAddr,
  input  logic          hWrite,
  input  logic [DW-1:0] hWdata,
  output logic          regionOk,
  output logic          secureHit,
  output logic          cfgHit,
  output logic [DW-1:0] cfgRdata
);

  localparam int WIN_LSB = CFG_OFF_W + 2;
  localparam logic [CFG_OFF_W-1:0] LOCK_WORD = CFG_OFF_W'(32);

  logic [CFG_OFF_W-1:0] offQ;
  logic                 lockQ;
  logic [AW-1:0]        baseQ  [NREG];
  logic [AW-1:0]        limitQ [NREG];
  logic [NREG-1:0]      rdQ;
  logic [NREG-1:0]      wrQ;
  logic [NREG-1:0]      hitVec;
  logic                 lockWrite;

  assign cfgHit    = (hAddr[AW-1:WIN_LSB] == CFG_BASE[AW-1:WIN_LSB]);
  assign secureHit = (hAddr >= SEC_BASE) && (hAddr <= SEC_LIMIT);
  assign regionOk  = |hitVec;
  assign lockWrite = strb.cfgWrite && !lockQ && (offQ == LOCK_WORD) && hWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offQ  <= '0;
      lockQ <= 1'b0;
    end else begin
      if (strb.capture) offQ <= hAddr[WIN_LSB-1:2];
      if (lockWrite)    lockQ <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < NREG; gi++) begin : g_region
    logic selThis;
    assign selThis = !offQ[5] && (offQ[4:2] == 3'(gi));
    assign hitVec[gi] = (hAddr >= baseQ[gi]) && (hAddr <= limitQ[gi]) &&
                        (hWrite ? wrQ[gi] : rdQ[gi]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ[gi]  <= '0;
        limitQ[gi] <= '0;
        rdQ[gi]    <= 1'b0;
        wrQ[gi]    <= 1'b0;
      end else if (strb.cfgWrite && !lockQ && selThis) begin
        case (offQ[1:0])
          2'd0: baseQ[gi]  <= hWdata[AW-1:0];
          2'd1: limitQ[gi] <= hWdata[AW-1:0];
          2'd2: begin
            rdQ[gi] <= hWdata[0];
            wrQ[gi] <= hWdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    cfgRdata = '0;
    if (offQ == LOCK_WORD) begin
      cfgRdata[0] = lockQ;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (!offQ[5] && (offQ[4:2] == 3'(i))) begin
          case (offQ[1:0])
            2'd0:    cfgRdata[AW-1:0] = baseQ[i];
            2'd1:    cfgRdata[AW-1:0] = limitQ[i];
            2'd2:    cfgRdata[1:0]    = {wrQ[i], rdQ[i]};
            default: cfgRdata         = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/mpf_ctrl.sv
module mpf_ctrl
  import mpf_pkg::*;
#(
  parameter int               MIDW       = 4,
  parameter logic [MIDW-1:0]  TRUSTED_ID = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hSel,
  input  logic            hTransSeq,
  input  logic            hWrite,
  input  logic            hReady,
  input  logic [MIDW-1:0] hMaster,
  input  logic            regionOk,
  input  logic            secureHit,
  input  logic            cfgHit,
  input  logic            sReadyOut,
  input  logic            sResp,
  output strobe_t         strb,
  output phase_e          phase,
  output logic            sSel,
  output logic            hReadyOut,
  output logic            hResp
);

  logic   trusted;
  logic   permit;
  logic   accept;
  logic   cfgWrQ;
  phase_e kind;
  phase_e phaseNext;

  assign trusted = (hMaster == TRUSTED_ID);
  assign permit  = trusted || (regionOk && !secureHit);
  assign sSel    = hSel && !cfgHit && permit;
  assign accept  = hSel && hTransSeq && hReady;

  always_comb begin
    if (cfgHit)      kind = trusted ? PH_CFG : PH_ERR1;
    else if (permit) kind = PH_FWD;
    else             kind = PH_ERR1;
  end

  always_comb begin
    phaseNext = phase;
    if (phase == PH_ERR1)  phaseNext = PH_ERR2;
    else if (hReady)       phaseNext = accept ? kind : PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cfgWrQ <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (accept) cfgWrQ <= hWrite;
    end
  end

  assign strb.capture  = accept && cfgHit && trusted;
  assign strb.cfgWrite = (phase == PH_CFG) && cfgWrQ;

  always_comb begin
    case (phase)
      PH_FWD:  begin hReadyOut = sReadyOut; hResp = sResp; end
      PH_ERR1: begin hReadyOut = 1'b0;      hResp = 1'b1;  end
      PH_ERR2: begin hReadyOut = 1'b1;      hResp = 1'b1;  end
      default: begin hReadyOut = 1'b1;      hResp = 1'b0;  end
    endcase
  end

endmodule

// File: rtl/master_perm_filter.sv
module master_perm_filter
  import mpf_pkg::*;
#(
  parameter int               AW         = 32,
  parameter int               DW         = 32,
  parameter int               MIDW       = 4,
  parameter int               NREG       = 4,
  parameter logic [MIDW-1:0]  TRUSTED_ID = '0,
  parameter logic [AW-1:0]    CFG_BASE   = 32'h4000_0000,
  parameter logic [AW-1:0]    SEC_BASE   = 32'h5000_0000,
  parameter logic [AW-1:0]    SEC_LIMIT  = 32'h5000_FFFF
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            hSel,
  input  logic [AW-1:0]   hAddr,
  input  logic [1:0]      hTrans,
  input  logic            hWrite,
  input  logic [DW-1:0]   hWdata,
  input  logic [MIDW-1:0] hMaster,
  input  logic            hReady,
  output logic            hReadyOut,
  output logic            hResp,
  output logic [DW-1:0]   hRdata,
  output logic            sSel,
  output logic [AW-1:0]   sAddr,
  output logic [1:0]      sTrans,
  output logic            sWrite,
  output logic [DW-1:0]   sWdata,
  input  logic [DW-1:0]   sRdata,
  input  logic            sReadyOut,
  input  logic            sResp
);

  strobe_t       strb;
  phase_e        phase;
  logic          regionOk;
  logic          secureHit;
  logic          cfgHit;
  logic [DW-1:0] cfgRdata;

  mpf_rules #(
    .AW(AW), .DW(DW), .NREG(NREG),
    .CFG_BASE(CFG_BASE), .SEC_BASE(SEC_BASE), .SEC_LIMIT(SEC_LIMIT)
  ) u_rules (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hAddr(hAddr), .hWrite(hWrite), .hWdata(hWdata),
    .regionOk(regionOk), .secureHit(secureHit), .cfgHit(cfgHit),
    .cfgRdata(cfgRdata)
  );

  mpf_ctrl #(
    .MIDW(MIDW), .TRUSTED_ID(TRUSTED_ID)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hTransSeq(hTrans[1]),
    .hWrite(hWrite), .hReady(hReady), .hMaster(hMaster),
    .regionOk(regionOk), .secureHit(secureHit), .cfgHit(cfgHit),
    .sReadyOut(sReadyOut), .sResp(sResp),
    .strb(strb), .phase(phase), .sSel(sSel),
    .hReadyOut(hReadyOut), .hResp(hResp)
  );

  assign sAddr  = hAddr;
  assign sWrite = hWrite;
  assign sWdata = hWdata;
  assign sTrans = sSel ? hTrans : 2'b00;

  always_comb begin
    case (phase)
      PH_FWD:  hRdata = sRdata;
      PH_CFG:  hRdata = cfgRdata;
      default: hRdata = '0;
    endcase
  end

endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int               AW         = 32,
  parameter int               MIDW       = 4,
  parameter logic [MIDW-1:0]  TRUSTED_ID = '0,
  parameter logic [AW-1:0]    CFG_BASE   = 32'h4000_0000,
  parameter logic [AW-1:0]    SEC_BASE   = 32'h5000_0000,
  parameter logic [AW-1:0]    SEC_LIMIT  = 32'h5000_FFFF
) (
  input logic            clk,
  input logic            rstN,
  input logic            hSel,
  input logic [1:0]      hTrans,
  input logic            hReady,
  input logic [AW-1:0]   hAddr,
  input logic [MIDW-1:0] hMaster,
  input logic            sSel,
  input logic [1:0]      sTrans,
  input logic            hReadyOut,
  input logic            hResp
);

  logic inCfg;
  logic inSec;
  logic isTrusted;
  assign inCfg     = (hAddr[AW-1:8] == CFG_BASE[AW-1:8]);
  assign inSec     = (hAddr >= SEC_BASE) && (hAddr <= SEC_LIMIT);
  assign isTrusted = (hMaster == TRUSTED_ID);

  AST_TRUSTED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (hSel && isTrusted && !inCfg) |-> sSel);  // R1

  AST_SECURE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (hSel && !isTrusted && inSec) |-> !sSel);  // R3

  AST_ERR_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (hResp && !hReadyOut) |=> (hResp && hReadyOut));  // R4

  AST_IDLE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !sSel |-> (sTrans == 2'b00));  // R4

  AST_CFG_UNTRUSTED_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (hSel && hTrans[1] && hReady && !isTrusted && inCfg) |=> (hResp && !hReadyOut));  // R7

endmodule

bind master_perm_filter mpf_checker #(
  .AW(AW), .MIDW(MIDW), .TRUSTED_ID(TRUSTED_ID),
  .CFG_BASE(CFG_BASE), .SEC_BASE(SEC_BASE), .SEC_LIMIT(SEC_LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .hSel(hSel), .hTrans(hTrans), .hReady(hReady),
  .hAddr(hAddr), .hMaster(hMaster), .sSel(sSel), .sTrans(sTrans),
  .hReadyOut(hReadyOut), .hResp(hResp)
);

// File: tb/master_perm_filter_bench.sv
`timescale 1ns/1ps
module master_perm_filter_bench;

  localparam logic [31:0] CFGB = 32'h4000_0000;
  localparam logic [31:0] SECB = 32'h5000_0000;
  localparam logic [31:0] SECL = 32'h5000_FFFF;
  localparam logic [31:0] KEY  = 32'h5A5A_0000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hSel = 1'b0;
  logic [31:0] hAddr = '0;
  logic [1:0]  hTrans = 2'b00;
  logic        hWrite = 1'b0;
  logic [31:0] hWdata = '0;
  logic [3:0]  hMaster = '0;
  logic        hReady;
  logic        hReadyOut;
  logic        hResp;
  logic [31:0] hRdata;
  logic        sSel;
  logic [31:0] sAddr;
  logic [1:0]  sTrans;
  logic        sWrite;
  logic [31:0] sWdata;
  logic [31:0] sRdata;
  logic        sReadyOut;
  logic        sResp;

  always #4 clk = ~clk;
  assign hReady = hReadyOut;

  master_perm_filter u_master_perm_filter (
    .clk(clk), .rstN(rstN), .hSel(hSel), .hAddr(hAddr), .hTrans(hTrans),
    .hWrite(hWrite), .hWdata(hWdata), .hMaster(hMaster), .hReady(hReady),
    .hReadyOut(hReadyOut), .hResp(hResp), .hRdata(hRdata),
    .sSel(sSel), .sAddr(sAddr), .sTrans(sTrans), .sWrite(sWrite),
    .sWdata(sWdata), .sRdata(sRdata), .sReadyOut(sReadyOut), .sResp(sResp)
  );

  // Slave model with programmable wait states
  int          slvWaits = 0;
  int          slvCnt;
  logic        slvActive;
  logic [31:0] slvAddr;
  assign sReadyOut = !(slvActive && slvCnt != 0);
  assign sRdata    = slvAddr ^ KEY;
  assign sResp     = 1'b0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slvActive <= 1'b0; slvCnt <= 0; slvAddr <= '0;
    end else if (slvActive && slvCnt != 0) begin
      slvCnt <= slvCnt - 1;
    end else begin
      slvActive <= sSel && sTrans[1] && hReady;
      slvAddr   <= sAddr;
      slvCnt    <= slvWaits;
    end
  end

  int nChecks = 0;
  int nErr    = 0;
  logic [31:0] mBase  [4];
  logic [31:0] mLimit [4];
  logic [1:0]  mPerm  [4];
  logic        mLock;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit expPermit(logic [3:0] mid, logic [31:0] a, logic wr);
    if (mid == 4'd0) return 1'b1;
    if (a >= SECB && a <= SECL) return 1'b0;
    for (int i = 0; i < 4; i++)
      if (a >= mBase[i] && a <= mLimit[i] && (wr ? mPerm[i][1] : mPerm[i][0])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic xfer(input logic [3:0] mid, input logic [31:0] addr, input logic wr,
                      input logic [31:0] wd, output logic sawSel, output logic firstRdy,
                      output logic firstResp, output logic lastResp,
                      output logic [31:0] rd, output int cyc);
    @(negedge clk);
    hSel = 1'b1; hTrans = 2'b10; hAddr = addr; hWrite = wr; hMaster = mid;
    #1 sawSel = sSel;
    @(posedge clk); @(negedge clk);
    hSel = 1'b0; hTrans = 2'b00; hWdata = wd;
    #1 firstRdy = hReadyOut; firstResp = hResp; cyc = 1;
    while (!hReadyOut && cyc < 20) begin
      @(posedge clk); @(negedge clk); #1; cyc++;
    end
    rd = hRdata; lastResp = hResp;
  endtask

  // Bus access outside the configuration window, checked against the model
  task automatic access(input logic [3:0] mid, input logic [31:0] addr, input logic wr, input string tag);
    logic s, fr, fp, lp; logic [31:0] rd; int cyc; bit exp;
    exp = expPermit(mid, addr, wr);
    xfer(mid, addr, wr, 32'hCAFE_0000 ^ addr, s, fr, fp, lp, rd, cyc);
    chk(s == exp, {tag, " sel"}, 32'(s), 32'(exp));
    if (exp) begin
      chk(!lp && cyc == slvWaits + 1, {tag, " fwd resp/cycles"}, 32'(cyc), 32'(slvWaits + 1));
      if (!wr) chk(rd == (addr ^ KEY), {tag, " rdata"}, rd, addr ^ KEY);
    end else begin
      chk(!fr && fp && lp && cyc == 2, {tag, " error pattern"}, {fr, fp, lp, 5'd0, 24'(cyc)}, {3'b011, 5'd0, 24'd2});
    end
  endtask

  task automatic cfgWr(input logic [3:0] mid, input logic [7:0] off, input logic [31:0] d,
                       output logic errOut, output logic selOut);
    logic fr, fp, lp; logic [31:0] rd; int cyc;
    xfer(mid, CFGB | 32'(off), 1'b1, d, selOut, fr, fp, lp, rd, cyc);
    errOut = lp;
  endtask

  task automatic cfgRd(input logic [7:0] off, output logic [31:0] rd, output logic errOut);
    logic s, fr, fp, lp; int cyc;
    xfer(4'd0, CFGB | 32'(off), 1'b0, 32'd0, s, fr, fp, lp, rd, cyc);
    errOut = lp || s || cyc != 1;
  endtask

  task automatic setRegion(input int i, input logic [31:0] b, input logic [31:0] l, input logic [1:0] p);
    logic e, s;
    cfgWr(4'd0, 8'(i * 16),     b,        e, s);
    cfgWr(4'd0, 8'(i * 16 + 4), l,        e, s);
    cfgWr(4'd0, 8'(i * 16 + 8), 32'(p),   e, s);
    if (!mLock) begin mBase[i] = b; mLimit[i] = l; mPerm[i] = p; end
  endtask

  initial begin
    #(200000 * 8);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic e, s;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin mBase[i] = '0; mLimit[i] = '0; mPerm[i] = '0; end
    mLock = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1 chk(hReadyOut && !hResp && !sSel, "R9 reset idle outputs", {hReadyOut, hResp, sSel}, 3'b100);

    // R9: registers clear, untrusted fully denied
    for (int i = 0; i < 4; i++) begin
      for (int f = 0; f < 3; f++) begin
        cfgRd(8'(i * 16 + f * 4), rd, e);
        chk(rd == 0 && !e, "R9 region reg after reset", rd, 0);
      end
    end
    cfgRd(8'h80, rd, e);
    chk(rd == 0, "R9 lock after reset", rd, 0);
    access(4'd1, 32'h1000_0100, 1'b0, "R9 untrusted read");
    access(4'd2, 32'h0000_0000, 1'b1, "R9 untrusted write");

    // R1: trusted reaches anything, secure window included
    access(4'd0, SECB + 32'h10, 1'b0, "R1 trusted secure read");
    access(4'd0, 32'h2000_0000, 1'b1, "R1 trusted write");

    // R6: programming and readback
    setRegion(0, 32'h1000_0100, 32'h1000_01FF, 2'b01);
    cfgRd(8'h00, rd, e); chk(rd == 32'h1000_0100 && !e, "R6 base readback", rd, 32'h1000_0100);
    cfgRd(8'h04, rd, e); chk(rd == 32'h1000_01FF && !e, "R6 limit readback", rd, 32'h1000_01FF);
    cfgRd(8'h08, rd, e); chk(rd == 32'h1 && !e, "R6 perm readback", rd, 1);
    cfgWr(4'd0, 8'h0C, 32'hFFFF_FFFF, e, s);
    chk(!e && !s, "R6 trusted cfg write okay, not forwarded", {e, s}, 0);

    // R2: inclusive boundaries and direction
    access(4'd1, 32'h1000_0100, 1'b0, "R2 read at base");
    access(4'd1, 32'h1000_01FC, 1'b0, "R2 read at top word");
    access(4'd1, 32'h1000_0200, 1'b0, "R2 read past limit");
    access(4'd1, 32'h1000_00FC, 1'b0, "R2 read below base");
    access(4'd1, 32'h1000_0100, 1'b1, "R2 write to read-only");
    setRegion(2, 32'h1000_0300, 32'h1000_0300, 2'b10);
    access(4'd3, 32'h1000_0300, 1'b1, "R2 write one-word region");
    access(4'd3, 32'h1000_0300, 1'b0, "R2 read write-only region");

    // R3: secure window stays closed even under a covering region
    setRegion(1, 32'h4FFF_0000, 32'h5001_0000, 2'b11);
    access(4'd1, SECB, 1'b0, "R3 secure read");
    access(4'd1, SECL - 3, 1'b1, "R3 secure write");
    access(4'd1, 32'h4FFF_0000, 1'b0, "R2 below secure window");
    access(4'd1, SECL + 1, 1'b0, "R2 above secure window");

    // R5: slave wait states pass through
    slvWaits = 3;
    access(4'd1, 32'h1000_0104, 1'b0, "R5 waited untrusted read");
    access(4'd0, 32'h3000_0010, 1'b0, "R5 waited trusted read");
    slvWaits = 0;

    // R7: untrusted configuration access refused
    cfgWr(4'd1, 8'h00, 32'hDEAD_BEEF, e, s);
    chk(e && !s, "R7 untrusted cfg write error", {e, s}, 2'b10);
    cfgRd(8'h00, rd, e); chk(rd == 32'h1000_0100, "R7 base unchanged", rd, 32'h1000_0100);
    begin
      logic fr, fp, lp; int cyc;
      xfer(4'd7, CFGB | 32'h04, 1'b0, 0, s, fr, fp, lp, rd, cyc);
      chk(!s && !fr && fp && lp && cyc == 2, "R7 untrusted cfg read error", {s, fr, fp, lp}, 4'b0011);
    end

    // R10: ID alone decides
    access(4'd0, 32'h7000_0000, 1'b0, "R10 id0 unmapped");
    access(4'd9, 32'h7000_0000, 1'b0, "R10 id9 unmapped");
    access(4'd15, 32'h1000_0108, 1'b0, "R10 id15 in region");

    // Random phase
    for (int i = 0; i < 4; i++) begin
      logic [31:0] b;
      b = 32'h1000_0000 + (32'($urandom_range(0, 'h1000)) & ~32'h3);
      setRegion(i, b, b + 32'($urandom_range(0, 'h400)), 2'($urandom_range(0, 3)));
    end
    for (int n = 0; n < 400; n++) begin
      int sel; logic [31:0] a; logic [3:0] mid;
      sel = $urandom_range(0, 9);
      if (sel < 8)       a = 32'h1000_0000 + (32'($urandom_range(0, 'h1400)) & ~32'h3);
      else if (sel == 8) a = SECB + (32'($urandom_range(0, 'hFFFF)) & ~32'h3);
      else               a = 32'h2000_0000 + (32'($urandom_range(0, 'hFF)) << 2);
      mid = ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(1, 15));
      slvWaits = $urandom_range(0, 2);
      access(mid, a, 1'($urandom_range(0, 1)), "R2 random access");
    end
    slvWaits = 0;

    // R8: lock freezes rules
    cfgWr(4'd0, 8'h80, 32'h1, e, s);
    mLock = 1'b1;
    cfgRd(8'h80, rd, e); chk(rd == 1, "R8 lock reads set", rd, 1);
    setRegion(0, 32'h9000_0000, 32'h9000_FFFF, 2'b11);
    cfgRd(8'h00, rd, e); chk(rd == mBase[0], "R8 base frozen", rd, mBase[0]);
    cfgRd(8'h08, rd, e); chk(rd == 32'(mPerm[0]), "R8 perm frozen", rd, 32'(mPerm[0]));
    cfgWr(4'd0, 8'h80, 32'h0, e, s);
    chk(!e, "R8 locked write okay", 32'(e), 0);
    cfgRd(8'h80, rd, e); chk(rd == 1, "R8 lock sticky", rd, 1);
    access(4'd1, 32'h9000_0000, 1'b0, "R8 new rule ineffective");
    access(4'd1, mBase[0], 1'b0, "R8 old rule kept");

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule